// File: doc/BRIEF.md
# Input Power Over-Limit Warning and Peak Monitor

This block watches a stream of raw input-power codes. Each code is the product of input current and input voltage, formed upstream and presented with a valid strobe. The block compares every valid code against a programmable warning threshold. When a code exceeds the threshold, it raises a sticky warning flag and an alert request. At the same time it tracks the largest code seen, and software can read and clear that value.

Software reaches the block through a small command port. Each access carries a command code, a write qualifier and a data field. The threshold sits at code D4h and is readable and writable. The peak value sits at code D5h and is read-only. Code D6h is a write that carries no data and clears the peak. A separate strobe clears the warning. The block only warns: it has no fault path and never acts on the external switch.

Top module: `pwr_peak_monitor`

## Requirements
- R1: After reset the threshold reads 0FFFh, the peak reads 0h, and warn_flag and alert_req are both low.
- R2: A write (cmd_valid=1, cmd_write=1) with cmd_code D4h loads cmd_wdata into the threshold. A read (cmd_valid=1, cmd_write=0) with code D4h returns the threshold zero-extended to 16 bits on cmd_rdata in the same cycle. cmd_rdata is 0 whenever no read is presented.
- R3: A valid sample strictly greater than the threshold sets warn_flag and alert_req on the next clock edge. A sample equal to the threshold does not set them, and neither does a sample with smp_valid low.
- R4: While the threshold is 0FFFh, no sample sets the warning. Threshold 0FFEh is still active, so a sample of 0FFFh then warns.
- R5: warn_flag stays set, even after samples fall below the threshold, until a warn_clr pulse clears it on the next edge. If an exceeding sample and warn_clr arrive in the same cycle, the flag ends up set.
- R6: The peak register holds the largest valid sample since reset or since the last clear. Samples that are not larger leave it unchanged. Reads at D5h return it zero-extended, and writes at D5h have no effect.
- R7: A write with code D6h clears the peak to 0 on the next edge, whatever cmd_wdata holds. A valid sample in that same cycle is discarded, and the next valid sample sets the peak to its own value.
- R8: A sample is compared against the threshold held before the edge. A threshold write in the same cycle as a sample takes effect only for later samples.
- R9: A write with any other command code changes nothing, and a read of any other code returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies smp_data this cycle |
| smp_data | input | 12 | Raw input-power code |
| cmd_valid | input | 1 | Command access present this cycle |
| cmd_write | input | 1 | 1 = write/command, 0 = read |
| cmd_code | input | 8 | Command code (D4h threshold, D5h peak, D6h clear peak) |
| cmd_wdata | input | 12 | Write data for the threshold |
| cmd_rdata | output | 16 | Read data, combinational from the presented code |
| warn_clr | input | 1 | Clears the sticky warning |
| warn_flag | output | 1 | Sticky over-power warning |
| alert_req | output | 1 | Request to assert the alert line |

## Verification
Three pairs of functions can act in the same cycle. A peak-clear command can coincide with a valid sample. A warning-clear strobe can coincide with an exceeding sample. A threshold write can coincide with a sample. The bench drives each pair in a single cycle. It then checks, on the following cycle, that the clear wins for the peak, that the new event wins for the warning, and that the old threshold decided the comparison. For each pair it applies one more lone stimulus, to show that the state left behind is the one the requirement predicts.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CMD_LIMIT      = 8'hD4;
    localparam logic [CODE_W-1:0] CMD_PEAK       = 8'hD5;
    localparam logic [CODE_W-1:0] CMD_PEAK_CLEAR = 8'hD6;
endpackage

// File: rtl/pwr_warn_unit.sv
module pwr_warn_unit #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lim_we,
    input  logic [DATA_W-1:0] lim_wdata,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              warn_clr,
    output logic [DATA_W-1:0] limit,
    output logic              warn
);
    localparam logic [DATA_W-1:0] LIM_OFF = '1;

    typedef struct packed {
        logic [DATA_W-1:0] limit;
        logic              warn;
    } warn_st_t;

    warn_st_t st_d, st_q;
    logic     over_d;

    always_comb begin
        st_d   = st_q;
        over_d = smp_valid && (st_q.limit != LIM_OFF) && (smp_data > st_q.limit);
        if (lim_we)   st_d.limit = lim_wdata;
        if (warn_clr) st_d.warn  = 1'b0;
        if (over_d)   st_d.warn  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.limit <= LIM_OFF;
            st_q.warn  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign limit = st_q.limit;
    assign warn  = st_q.warn;

    assert_over_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && limit != LIM_OFF && smp_data > limit) |=> warn);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn && limit == LIM_OFF) |=> !warn);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warn && !warn_clr) |=> warn);

    assert_limit_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we |=> (limit == $past(lim_wdata)));
endmodule

// File: rtl/pwr_peak_hold.sv
module pwr_peak_hold #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              peak_clr,
    output logic [DATA_W-1:0] peak
);
    typedef struct packed {
        logic [DATA_W-1:0] peak;
    } peak_st_t;

    peak_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_valid && (smp_data > st_q.peak)) st_d.peak = smp_data;
        if (peak_clr) st_d.peak = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.peak <= '0;
        else        st_q      <= st_d;
    end

    assign peak = st_q.peak;

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        peak_clr |=> (peak == '0));

    assert_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_clr |=> (peak >= $past(peak)));

    assert_covers_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !peak_clr) |=> (peak >= $past(smp_data)));
endmodule

// File: rtl/pwr_peak_monitor.sv
module pwr_peak_monitor
    import pwr_mon_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int RD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [RD_W-1:0]   cmd_rdata,
    input  logic              warn_clr,
    output logic              warn_flag,
    output logic              alert_req
);
    localparam int PAD_W = RD_W - DATA_W;

    logic              wr_acc, rd_acc;
    logic              lim_we, peak_clr;
    logic [DATA_W-1:0] limit_w, peak_w;
    logic [DATA_W-1:0] rd_sel;
    logic              warn_w;

    assign wr_acc   = cmd_valid && cmd_write;
    assign rd_acc   = cmd_valid && !cmd_write;
    assign lim_we   = wr_acc && (cmd_code == CMD_LIMIT);
    assign peak_clr = wr_acc && (cmd_code == CMD_PEAK_CLEAR);

    pwr_warn_unit #(.DATA_W(DATA_W)) u_warn (
        .clk       (clk),
        .rst_n     (rst_n),
        .lim_we    (lim_we),
        .lim_wdata (cmd_wdata),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .warn_clr  (warn_clr),
        .limit     (limit_w),
        .warn      (warn_w)
    );

    pwr_peak_hold #(.DATA_W(DATA_W)) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .peak_clr  (peak_clr),
        .peak      (peak_w)
    );

    always_comb begin
        rd_sel = '0;
        if (rd_acc) begin
            case (cmd_code)
                CMD_LIMIT: rd_sel = limit_w;
                CMD_PEAK:  rd_sel = peak_w;
                default:   rd_sel = '0;
            endcase
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign cmd_rdata = {{PAD_W{1'b0}}, rd_sel};
        end else begin : g_nopad
            assign cmd_rdata = rd_sel[RD_W-1:0];
        end
    endgenerate

    assign warn_flag = warn_w;
    assign alert_req = warn_w;

    assert_alert_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_req) |-> $past(smp_valid));
endmodule

// File: tb/pwr_peak_monitor_test.sv
module pwr_peak_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [11:0] cmd_wdata = '0;
    logic [15:0] cmd_rdata;
    logic        warn_clr = 1'b0;
    logic        warn_flag, alert_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwr_peak_monitor uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .warn_clr(warn_clr),
        .warn_flag(warn_flag), .alert_req(alert_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, release after the next negedge.
    task automatic cyc(input logic sv, input logic [11:0] sd, input logic cv,
                       input logic [7:0] code, input logic [11:0] wd, input logic wc);
        smp_valid = sv; smp_data = sd;
        cmd_valid = cv; cmd_write = cv; cmd_code = code; cmd_wdata = wd;
        warn_clr  = wc;
        @(posedge clk); @(negedge clk);
        smp_valid = 0; cmd_valid = 0; cmd_write = 0; warn_clr = 0;
    endtask

    task automatic rd(input logic [7:0] code, output logic [15:0] v);
        cmd_valid = 1; cmd_write = 0; cmd_code = code;
        #1 v = cmd_rdata;
        cmd_valid = 0;
        #1;
    endtask

    task automatic samp(input logic [11:0] d);
        cyc(1'b1, d, 1'b0, 8'h00, 12'h000, 1'b0);
    endtask

    task automatic wr(input logic [7:0] code, input logic [11:0] d);
        cyc(1'b0, 12'h000, 1'b1, code, d, 1'b0);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 warn", {15'd0, warn_flag}, 16'd0);
        chk("R1 alert", {15'd0, alert_req}, 16'd0);
        rd(8'hD4, v); chk("R1 limit", v, 16'h0FFF);
        rd(8'hD5, v); chk("R1 peak", v, 16'h0000);
        chk("R2 idle rdata", cmd_rdata, 16'h0000);
    endtask

    task automatic t_limit_rw;
        logic [15:0] v;
        wr(8'hD4, 12'h123);
        rd(8'hD4, v); chk("R2 limit rw", v, 16'h0123);
    endtask

    task automatic t_disabled;
        wr(8'hD4, 12'hFFF);
        samp(12'hFFF); samp(12'hFFE);
        chk("R4 disabled", {15'd0, warn_flag}, 16'd0);
        wr(8'hD4, 12'hFFE);
        samp(12'hFFF);
        chk("R4 FFE active", {15'd0, warn_flag}, 16'd1);
        cyc(1'b0, 12'h0, 1'b0, 8'h00, 12'h0, 1'b1);
        chk("R5 clear", {15'd0, warn_flag}, 16'd0);
    endtask

    task automatic t_threshold;
        wr(8'hD4, 12'h800);
        samp(12'h800);
        chk("R3 equal no warn", {15'd0, warn_flag}, 16'd0);
        cyc(1'b0, 12'h900, 1'b0, 8'h00, 12'h0, 1'b0);
        chk("R3 invalid ignored", {15'd0, warn_flag}, 16'd0);
        samp(12'h801);
        chk("R3 warn set", {15'd0, warn_flag}, 16'd1);
        chk("R3 alert set", {15'd0, alert_req}, 16'd1);
    endtask

    task automatic t_sticky;
        samp(12'h010); samp(12'h000);
        chk("R5 sticky", {15'd0, warn_flag}, 16'd1);
        cyc(1'b0, 12'h0, 1'b0, 8'h00, 12'h0, 1'b1);
        chk("R5 cleared", {15'd0, alert_req}, 16'd0);
        cyc(1'b1, 12'h900, 1'b0, 8'h00, 12'h0, 1'b1);
        chk("R5 set beats clear", {15'd0, warn_flag}, 16'd1);
        cyc(1'b0, 12'h0, 1'b0, 8'h00, 12'h0, 1'b1);
    endtask

    task automatic t_peak;
        logic [15:0] v;
        wr(8'hD6, 12'h000);
        samp(12'h100); samp(12'h300); samp(12'h200);
        rd(8'hD5, v); chk("R6 max", v, 16'h0300);
        cyc(1'b0, 12'hAAA, 1'b0, 8'h00, 12'h0, 1'b0);
        wr(8'hD5, 12'h7FF);
        rd(8'hD5, v); chk("R6 ignored", v, 16'h0300);
    endtask

    task automatic t_clear_race;
        logic [15:0] v;
        cyc(1'b1, 12'h500, 1'b1, 8'hD6, 12'hABC, 1'b0);
        rd(8'hD5, v); chk("R7 clear wins", v, 16'h0000);
        samp(12'h050);
        rd(8'hD5, v); chk("R7 restart", v, 16'h0050);
    endtask

    task automatic t_same_cycle_limit;
        logic [15:0] v;
        wr(8'hD4, 12'h100);
        cyc(1'b1, 12'h400, 1'b1, 8'hD4, 12'h900, 1'b0);
        chk("R8 old limit", {15'd0, warn_flag}, 16'd1);
        rd(8'hD4, v); chk("R8 new limit", v, 16'h0900);
        cyc(1'b0, 12'h0, 1'b0, 8'h00, 12'h0, 1'b1);
        samp(12'h400);
        chk("R8 new limit applies", {15'd0, warn_flag}, 16'd0);
    endtask

    task automatic t_unknown;
        logic [15:0] v;
        wr(8'h55, 12'h001);
        rd(8'hD4, v); chk("R9 limit kept", v, 16'h0900);
        rd(8'hD5, v); chk("R9 peak kept", v, 16'h0400);
        rd(8'h55, v); chk("R9 unknown read", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_limit_rw;
        t_disabled;
        t_threshold;
        t_sticky;
        t_peak;
        t_clear_race;
        t_same_cycle_limit;
        t_unknown;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule